// File: doc/BRIEF.md
# I2C Master Acknowledge and Stop Sequencer

This block finishes each byte for an I2C master. When the byte engine has moved the ninth-clock data, software either asks for an acknowledge bit to be clocked out, or asks for a Stop condition to be placed on the bus. The block drives the two open-drain lines through "pull low" outputs and watches the real line levels through a two-flop synchronizer. Every timed phase counts one baud period of `brg_reload + 1` system clocks. A timed phase that follows a release of a line waits until that line is seen high, so a slave that stretches SCL lengthens the phase by the length of the stretch.

Control is a set of register-style strobes: one to start an acknowledge (with the bit value to send), one to start a Stop, and a data buffer write port. Software sees a sticky interrupt flag, a stop-detected flag and a write-collision flag. A buffer write made while a sequence runs is dropped and flags a collision. After an acknowledge the block keeps SCL low so the next byte can be set up. After a Stop it leaves both lines released.

Top module: `i2c_ack_stop_seq`

## Requirements
- R1: Starting an acknowledge pulls SCL low at once. For the whole acknowledge, SDA is pulled low when the requested bit is 0 (ACK) and released when it is 1 (NACK).
- R2: After `brg_reload + 1` clocks with SCL low, SCL is released. With no stretching, SCL stays released for `brg_reload + 4` clocks. This is the two synchronizer stages, plus one cycle to see the line high, plus one baud period.
- R3: When another device holds SCL low after the release, or during the high period, the released interval grows by exactly the number of cycles it is held.
- R4: When the acknowledge ends, SCL is pulled low again, SDA is released, the acknowledge busy bit clears and the interrupt flag sets, all on the same edge.
- R5: Starting a Stop pulls SDA low while SCL stays low. SCL is released only after SDA has been seen low and one baud period has then passed. SDA is released `brg_reload + 4` clocks after SCL is released, plus any cycles in which SCL is held low by another device.
- R6: The stop-detected flag sets when SDA is seen high while SCL is high. `brg_reload + 4` clocks after SDA is released, the stop busy bit clears and the interrupt flag sets. Both lines are left released.
- R7: A buffer write while idle loads `buf_wdata` into `buf_q`. A buffer write while either sequence is busy leaves `buf_q` unchanged and sets the write-collision flag.
- R8: The interrupt flag and the write-collision flag stay set until their own clear strobe. The stop-detected flag clears when a new sequence starts.
- R9: A cycle that raises both start strobes starts nothing. Start strobes that arrive while a sequence runs are ignored.
- R10: After reset both lines are released, both busy bits are 0 and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brg_reload | input | CNT_W | Baud reload value; one period is this value plus one clocks |
| ack_start | input | 1 | Strobe: begin acknowledge sequence |
| ack_data | input | 1 | Bit to send: 0 = ACK, 1 = NACK |
| stop_start | input | 1 | Strobe: begin Stop sequence |
| buf_wr | input | 1 | Data buffer write strobe |
| buf_wdata | input | DATA_W | Data buffer write value |
| irq_clr | input | 1 | Clears the interrupt flag |
| wcol_clr | input | 1 | Clears the write-collision flag |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| ack_busy | output | 1 | Acknowledge enable; clears by itself at the end |
| stop_busy | output | 1 | Stop enable; clears by itself at the end |
| irq | output | 1 | Sticky sequence-complete flag |
| stop_det | output | 1 | Stop condition seen on the bus |
| wcol | output | 1 | Sticky write-collision flag |
| buf_q | output | DATA_W | Data buffer contents |

## Verification
The bench measures, in clock cycles, the released-SCL window of an acknowledge and the two gaps of a Stop. It does this for two reload values, with and without a slave stretching SCL. A timer that started on the release edge instead of on the sampled level, or one that kept counting during a stretch, gives windows that are too short by a fixed offset or by the stretch length. Buffer writes made in the middle of a sequence must leave the buffer untouched and raise the sticky collision flag; a design that gated only on the start strobe would take the write. Simultaneous start strobes must leave the lines and busy bits as they were, and the bench checks the NACK level on SDA because an inverted bit polarity is a likely error.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_A_LOW,    // SCL low, ack bit on SDA, one period
    ST_A_REL,    // SCL released, waiting to see it high
    ST_A_HIGH,   // SCL high period
    ST_S_SDALO,  // SDA pulled low, waiting to see it low
    ST_S_LOW,    // SCL still low for one period
    ST_S_SCLR,   // SCL released, waiting to see it high
    ST_S_SCLH,   // SCL high before SDA release
    ST_S_SDAR,   // SDA released, waiting for stop on the bus
    ST_S_TAIL    // one period after stop seen
  } seq_state_t;

  function automatic logic is_timed(seq_state_t s);
    return (s == ST_A_LOW) || (s == ST_A_HIGH) || (s == ST_S_LOW) ||
           (s == ST_S_SCLH) || (s == ST_S_TAIL);
  endfunction
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= '1;
          else        stg[i] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= '1;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_baud_timer.sv
module i2c_baud_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] reload,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                   cnt_d = reload;
    else if (run && cnt_q != 0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R2: a load always starts a full period from the reload value
  assert_load_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(reload)));
  // R3: a paused timer keeps its count
  assert_pause_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !run) |=> $stable(cnt_q));
endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
  import i2c_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ack_set,
  input  logic ack_bit,
  input  logic stop_set,
  input  logic scl_s,
  input  logic sda_s,
  input  logic tmr_zero,
  output logic tmr_load,
  output logic tmr_run,
  output logic scl_low,
  output logic sda_low,
  output logic ack_busy,
  output logic stop_busy,
  output logic seq_start,
  output logic ack_done,
  output logic stop_done,
  output logic stop_seen
);
  seq_state_t state_q, state_d;
  logic       bit_q, bit_d;
  logic       park_q, park_d;
  logic       expire;

  always_comb begin
    tmr_run = (state_q == ST_A_LOW) || (state_q == ST_S_LOW) ||
              (((state_q == ST_A_HIGH) || (state_q == ST_S_SCLH) ||
                (state_q == ST_S_TAIL)) && scl_s);
    expire  = is_timed(state_q) && tmr_run && tmr_zero;
  end

  always_comb begin
    state_d   = state_q;
    bit_d     = bit_q;
    park_d    = park_q;
    seq_start = 1'b0;
    ack_done  = 1'b0;
    stop_done = 1'b0;
    stop_seen = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ack_set && !stop_set) begin
          state_d = ST_A_LOW; bit_d = ack_bit; seq_start = 1'b1;
        end else if (stop_set && !ack_set) begin
          state_d = ST_S_SDALO; seq_start = 1'b1;
        end
      end
      ST_A_LOW:   if (expire) state_d = ST_A_REL;
      ST_A_REL:   if (scl_s)  state_d = ST_A_HIGH;
      ST_A_HIGH:  if (expire) begin
        state_d = ST_IDLE; ack_done = 1'b1; park_d = 1'b1;
      end
      ST_S_SDALO: if (!sda_s) state_d = ST_S_LOW;
      ST_S_LOW:   if (expire) state_d = ST_S_SCLR;
      ST_S_SCLR:  if (scl_s)  state_d = ST_S_SCLH;
      ST_S_SCLH:  if (expire) state_d = ST_S_SDAR;
      ST_S_SDAR:  if (sda_s && scl_s) begin
        state_d = ST_S_TAIL; stop_seen = 1'b1;
      end
      ST_S_TAIL:  if (expire) begin
        state_d = ST_IDLE; stop_done = 1'b1; park_d = 1'b0;
      end
      default:    state_d = ST_IDLE;
    endcase
    tmr_load = (state_d != state_q) && is_timed(state_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= 1'b1;
      park_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      park_q  <= park_d;
    end
  end

  always_comb begin
    ack_busy  = (state_q == ST_A_LOW) || (state_q == ST_A_REL) ||
                (state_q == ST_A_HIGH);
    stop_busy = (state_q != ST_IDLE) && !ack_busy;
    unique case (state_q)
      ST_IDLE:                        scl_low = park_q;
      ST_A_LOW, ST_S_SDALO, ST_S_LOW: scl_low = 1'b1;
      default:                        scl_low = 1'b0;
    endcase
    if (ack_busy) sda_low = !bit_q;
    else          sda_low = (state_q == ST_S_SDALO) || (state_q == ST_S_LOW) ||
                            (state_q == ST_S_SCLR)  || (state_q == ST_S_SCLH);
  end

  // R9: conflicting start strobes leave the sequencer idle
  assert_both_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && ack_set && stop_set) |=> (state_q == ST_IDLE));
  // R5: SCL is never released during a stop unless SDA is pulled low
  assert_sda_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_busy && $fell(scl_low)) |-> sda_low);
  // R6: the stop completes only after the bus stop was seen
  assert_stop_seen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |-> (sda_s && scl_s && !sda_low && !scl_low));
endmodule

// File: rtl/i2c_ack_stop_seq.sv
module i2c_ack_stop_seq #(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  brg_reload,
  input  logic              ack_start,
  input  logic              ack_data,
  input  logic              stop_start,
  input  logic              buf_wr,
  input  logic [DATA_W-1:0] buf_wdata,
  input  logic              irq_clr,
  input  logic              wcol_clr,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  output logic              ack_busy,
  output logic              stop_busy,
  output logic              irq,
  output logic              stop_det,
  output logic              wcol,
  output logic [DATA_W-1:0] buf_q
);
  localparam int LINES = 2;

  logic [1:0]       rst_pipe;
  logic             rst_sn;
  logic [LINES-1:0] line_s;
  logic             tmr_load, tmr_run, tmr_zero;
  logic             seq_start, ack_done, stop_done, stop_seen;
  logic             busy;
  logic             irq_d, det_d, wcol_d;
  logic [DATA_W-1:0] buf_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  i2c_bus_sync #(.W(LINES), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_sn), .d({scl_in, sda_in}), .q(line_s));

  i2c_baud_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_sn), .load(tmr_load), .run(tmr_run),
    .reload(brg_reload), .zero(tmr_zero));

  i2c_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_sn),
    .ack_set(ack_start), .ack_bit(ack_data), .stop_set(stop_start),
    .scl_s(line_s[1]), .sda_s(line_s[0]), .tmr_zero(tmr_zero),
    .tmr_load(tmr_load), .tmr_run(tmr_run),
    .scl_low(scl_drive_low), .sda_low(sda_drive_low),
    .ack_busy(ack_busy), .stop_busy(stop_busy), .seq_start(seq_start),
    .ack_done(ack_done), .stop_done(stop_done), .stop_seen(stop_seen));

  assign busy = ack_busy || stop_busy;

  always_comb begin
    irq_d  = irq;
    det_d  = stop_det;
    wcol_d = wcol;
    buf_d  = buf_q;
    if (ack_done || stop_done) irq_d = 1'b1;
    else if (irq_clr)          irq_d = 1'b0;
    if (stop_seen)             det_d = 1'b1;
    else if (seq_start)        det_d = 1'b0;
    if (buf_wr && busy)        wcol_d = 1'b1;
    else if (wcol_clr)         wcol_d = 1'b0;
    if (buf_wr && !busy)       buf_d = buf_wdata;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      irq      <= 1'b0;
      stop_det <= 1'b0;
      wcol     <= 1'b0;
      buf_q    <= '0;
    end else begin
      irq      <= irq_d;
      stop_det <= det_d;
      wcol     <= wcol_d;
      buf_q    <= buf_d;
    end
  end

  // R4: the acknowledge ends with SCL held low and the flag raised
  assert_ack_end_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(ack_busy) |-> (irq && scl_drive_low && !sda_drive_low));
  // R7: a rejected write leaves the buffer as it was
  assert_buf_hold_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    (buf_wr && (ack_busy || stop_busy)) |=> ($stable(buf_q) && wcol));
  // R8: the collision flag holds until its clear
  assert_wcol_sticky_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    (wcol && !wcol_clr) |=> wcol);
  // R8: the interrupt flag holds until its clear
  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    (irq && !irq_clr) |=> irq);
endmodule

// File: tb/i2c_ack_stop_seq_tb.sv
`timescale 1ns/1ps
module i2c_ack_stop_seq_tb;
  localparam int CW = 8;
  localparam int DW = 8;
  localparam int K_SCLHI = 0, K_SDAGAP = 1, K_IRQGAP = 2;

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] brg_reload = 8'd5;
  logic ack_start = 0, ack_data = 0, stop_start = 0, buf_wr = 0;
  logic [DW-1:0] buf_wdata = '0;
  logic irq_clr = 0, wcol_clr = 0, slave_hold = 0;
  logic scl_in, sda_in;
  logic scl_drive_low, sda_drive_low, ack_busy, stop_busy, irq, stop_det, wcol;
  logic [DW-1:0] buf_q;

  int total = 0, bad = 0, cyc = 0;
  int exp_k[$], exp_w[$];
  int t_scl = 0, t_sda = 0;
  logic p_scl = 0, p_sda = 0, p_irq = 0, p_ack = 0, p_stop = 0;

  always #5 clk = ~clk;
  assign scl_in = !(scl_drive_low || slave_hold);
  assign sda_in = !sda_drive_low;

  i2c_ack_stop_seq #(.CNT_W(CW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .brg_reload(brg_reload),
    .ack_start(ack_start), .ack_data(ack_data), .stop_start(stop_start),
    .buf_wr(buf_wr), .buf_wdata(buf_wdata), .irq_clr(irq_clr),
    .wcol_clr(wcol_clr), .scl_in(scl_in), .sda_in(sda_in),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .ack_busy(ack_busy), .stop_busy(stop_busy), .irq(irq),
    .stop_det(stop_det), .wcol(wcol), .buf_q(buf_q));

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic expect_item(int k, int w);
    exp_k.push_back(k);
    exp_w.push_back(w);
  endtask

  task automatic observe(int k, int w, string req);
    if (exp_k.size() == 0) begin
      chk({req, " unexpected event"}, k, -1);
    end else begin
      chk({req, " event kind"}, k, exp_k.pop_front());
      chk({req, " width"}, w, exp_w.pop_front());
    end
  endtask

  // monitor: measures windows on the line drives and checks them against the queue
  always @(negedge clk) begin
    cyc++;
    if (p_scl && !scl_drive_low) t_scl = cyc;
    if (!p_scl && scl_drive_low && p_ack) observe(K_SCLHI, cyc - t_scl, "R2/R3");
    if (p_sda && !sda_drive_low && p_stop) begin
      observe(K_SDAGAP, cyc - t_scl, "R5");
      t_sda = cyc;
    end
    if (!p_irq && irq && p_stop) observe(K_IRQGAP, cyc - t_sda, "R6");
    p_scl = scl_drive_low; p_sda = sda_drive_low; p_irq = irq;
    p_ack = ack_busy; p_stop = stop_busy;
  end

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!ack_busy && !stop_busy) break;
    end
  endtask

  task automatic stretch(int s);
    if (s > 0) begin
      for (int i = 0; i < 2000; i++) begin
        @(negedge clk);
        if (!scl_drive_low) break;
      end
      repeat (s) @(negedge clk);
      slave_hold = 0;
    end
  endtask

  task automatic do_ack(bit d, int s);
    expect_item(K_SCLHI, int'(brg_reload) + 4 + s);
    if (s > 0) slave_hold = 1;
    @(negedge clk);
    ack_start = 1; ack_data = d;
    @(negedge clk);
    ack_start = 0;
    chk("R1 scl low at start", scl_drive_low, 1);
    chk("R1 sda level", sda_drive_low, d ? 0 : 1);
    fork
      stretch(s);
      wait_idle();
    join
    chk("R4 busy cleared", ack_busy, 0);
    chk("R4 irq set", irq, 1);
    chk("R4 scl low again", scl_drive_low, 1);
    chk("R4 sda released", sda_drive_low, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic do_stop(int s);
    expect_item(K_SDAGAP, int'(brg_reload) + 4 + s);
    expect_item(K_IRQGAP, int'(brg_reload) + 4);
    @(negedge clk);
    stop_start = 1;
    @(negedge clk);
    stop_start = 0;
    chk("R5 sda low first", sda_drive_low, 1);
    chk("R5 scl still low", scl_drive_low, 1);
    if (s > 0) slave_hold = 1;
    fork
      stretch(s);
      wait_idle();
    join
    chk("R6 stop detected", stop_det, 1);
    chk("R6 irq set", irq, 1);
    chk("R6 scl released", scl_drive_low, 0);
    chk("R6 sda released", sda_drive_low, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got hang expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R10 reset state
    chk("R10 scl", scl_drive_low, 0);
    chk("R10 sda", sda_drive_low, 0);
    chk("R10 busy", ack_busy | stop_busy, 0);
    chk("R10 flags", {irq, stop_det, wcol}, 0);
    // R7 idle write accepted
    buf_wdata = 8'hA5; buf_wr = 1;
    @(negedge clk); buf_wr = 0;
    chk("R7 idle write", buf_q, 8'hA5);

    // R1 R2 R4 plain ACK
    do_ack(0, 0);
    // R8 irq sticky then clears
    repeat (10) @(negedge clk);
    chk("R8 irq sticky", irq, 1);
    clear_irq();
    chk("R8 irq cleared", irq, 0);

    // R7 collision during ack
    @(negedge clk); ack_start = 1; ack_data = 0;
    @(negedge clk); ack_start = 0;
    buf_wdata = 8'h3C; buf_wr = 1;
    @(negedge clk); buf_wr = 0;
    chk("R7 write rejected", buf_q, 8'hA5);
    chk("R7 collision flag", wcol, 1);
    stop_start = 1;
    @(negedge clk); stop_start = 0;
    chk("R9 stop ignored while busy", stop_busy, 0);
    exp_k.push_back(K_SCLHI); exp_w.push_back(int'(brg_reload) + 4);
    wait_idle();
    repeat (10) @(negedge clk);
    chk("R8 wcol sticky", wcol, 1);
    wcol_clr = 1; @(negedge clk); wcol_clr = 0;
    chk("R8 wcol cleared", wcol, 0);
    clear_irq();

    // R1 R3 NACK with stretch at release
    do_ack(1, 7);
    clear_irq();

    // R9 both strobes together
    @(negedge clk); ack_start = 1; stop_start = 1;
    @(negedge clk); ack_start = 0; stop_start = 0;
    repeat (3) @(negedge clk);
    chk("R9 no sequence", ack_busy | stop_busy, 0);
    chk("R9 lines unchanged", {scl_drive_low, sda_drive_low}, 2'b10);

    // R5 R6 stop
    do_stop(0);
    clear_irq();
    // R8 stop_det clears on next start
    brg_reload = 8'd2;
    do_ack(0, 0);
    chk("R8 stop_det cleared", stop_det, 0);
    clear_irq();
    // R5 stop with SCL stretched at release
    do_stop(4);

    repeat (5) @(negedge clk);
    chk("scoreboard drained", exp_k.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule